// File: doc/BRIEF.md
# Marker-Bit UART Transmitter

This block turns one byte into a 10-bit asynchronous frame on a single serial line. Bit times come from a divide-by-16 counter that advances on every 16x oversampling tick and runs freely, whether or not a frame is in flight. A byte write does not start the line at once. It stores the byte, marks a request as pending, and the frame begins at the next counter wrap. Every bit edge on the line therefore falls on a wrap of that counter.

The shift register is one bit wider than the data. The extra top bit holds a marker 1, and a 0 enters from the top on every shift. The controller knows the frame is over when the marker sits directly above the output bit and everything above it is 0. No bit counter is needed. A sticky done flag reports the end of each frame, and software clears it with a pulse on a clear input.

Top module: `mbit_uart_tx`

## Requirements
- R1: After reset the serial line is 1 and both `busy` and `done` are 0.
- R2: A frame is a start bit of 0, then the 8 data bits least significant first, then a stop bit of 1. Each bit lasts 16 ticks of `os_tick`.
- R3: The start bit begins at the first counter wrap after the cycle of the write. The first wrap is the 16th tick counted from reset, and every 16th tick after that is also a wrap. The falling edge therefore comes between 1 and 16 ticks after the write.
- R4: `done` rises at the 10th wrap after the write, which is exactly 144 ticks after the start bit begins. `busy` falls in the same cycle.
- R5: `done` stays 1 until `clr_done` is pulsed, and it reads 0 in the cycle after the pulse.
- R6: When `clr_done` is high in the cycle that would set `done`, the clear wins and `done` stays 0.
- R7: `busy` is 1 from the cycle after an accepted write until the end of the frame. A write made while `busy` is 1 is ignored, and the frame in flight keeps its original data.
- R8: While `busy` is 0, the serial line is 1.
- R9: The divide-by-16 counter keeps running while the transmitter is idle. A byte written just after `done` rises starts its start bit exactly 16 ticks after `done` rose, so the stop bit lasts one full bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| clr_done | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output |
| busy | output | 1 | A frame is pending or in flight |
| done | output | 1 | Sticky end-of-frame flag |

## Verification
The bench measures every edge in units of oversampling ticks. It targets start-latency errors first: a design that starts on the write instead of on a wrap, or one that resets the counter on the write, shows a start gap outside 1..16 ticks, or a back-to-back stop bit other than 16 ticks. Marker-detection mistakes shorten or lengthen the frame. Those show up as a wrong bit at a mid-bit sample, or as `done` appearing at a tick other than 144. Further runs write a second byte in the middle of a frame, which corrupts the data when writes during `busy` are not ignored. They also hold the clear high across the set, which catches a design where the set beats the clear.

// File: rtl/mbit_pkg.sv
package mbit_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_START = 2'd2,
    TX_DATA  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/mbit_divider.sv
module mbit_divider #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  output logic roll
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (os_tick) begin
      if (cnt_q == CNT_MAX) cnt_d = '0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign roll = os_tick && (cnt_q == CNT_MAX);

  // R9: the counter moves only on ticks and wraps after OVERSAMPLE of them
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> (cnt_q == (($past(cnt_q) == CNT_MAX) ? '0 : CNT_W'($past(cnt_q) + 1'b1))));
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !os_tick |=> $stable(cnt_q));
endmodule

// File: rtl/mbit_shifter.sv
module mbit_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] load_data,
  output logic              out_bit,
  output logic              last
);
  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = {1'b1, load_data};
    else if (shift) sr_d = {1'b0, sr_q[SR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign out_bit = sr_q[0];
  // marker directly above the output bit, nothing but zeros above it
  assign last    = sr_q[1] && (sr_q[SR_W-1:2] == '0);

  // R2: after a shift the top position has been refilled with zero
  a_r2_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (sr_q[SR_W-1] == 1'b0));
endmodule

// File: rtl/mbit_ctrl.sv
module mbit_ctrl
  import mbit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic roll,
  input  logic wr_en,
  input  logic clr_done,
  input  logic last,
  input  logic out_bit,
  output logic load,
  output logic shift,
  output logic txd,
  output logic busy,
  output logic done
);
  tx_state_e state_q, state_d;
  logic      done_q, done_d, set_done;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    shift    = 1'b0;
    set_done = 1'b0;
    unique case (state_q)
      TX_IDLE:  if (wr_en) begin
                  load    = 1'b1;
                  state_d = TX_WAIT;
                end
      TX_WAIT:  if (roll) state_d = TX_START;
      TX_START: if (roll) state_d = TX_DATA;
      TX_DATA:  if (roll) begin
                  shift = 1'b1;
                  if (last) begin
                    set_done = 1'b1;
                    state_d  = TX_IDLE;
                  end
                end
      default:  state_d = TX_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_q;
    if (clr_done)      done_d = 1'b0;
    else if (set_done) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = out_bit;
      default:  txd = 1'b1;
    endcase
  end

  assign busy = (state_q != TX_IDLE);
  assign done = done_q;

  // R5: done holds until cleared
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_done) |=> done);
  // R6: a clear always leaves done low in the next cycle
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !done);
  // R7: busy only rises after a write strobe
  a_r7_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));
  // R4: done only rises on a counter wrap, as the frame ends
  a_r4_done_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(roll) && !busy));
endmodule

// File: rtl/mbit_uart_tx.sv
module mbit_uart_tx #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_done,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  logic roll, load, shift, out_bit, last;

  mbit_divider #(.OVERSAMPLE(OVERSAMPLE)) u_div (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .roll(roll)
  );

  mbit_shifter #(.DATA_W(DATA_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .load_data(wr_data), .out_bit(out_bit), .last(last)
  );

  mbit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .roll(roll), .wr_en(wr_en),
    .clr_done(clr_done), .last(last), .out_bit(out_bit),
    .load(load), .shift(shift), .txd(txd), .busy(busy), .done(done)
  );

  // R8: line idles high
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R3: every falling edge on the line lands on a counter wrap
  a_r3_fall_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(roll));
endmodule

// File: tb/mbit_uart_tx_test.sv
module mbit_uart_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       clr_done = 1'b0;
  logic       txd, busy, done;

  int checks = 0;
  int fails  = 0;
  int tcount = 0;
  int tick_div = 1;
  int divc = 0;
  int last_done_tick = 0;

  mbit_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en),
    .wr_data(wr_data), .clr_done(clr_done), .txd(txd), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (divc >= tick_div - 1) begin
      os_tick <= 1'b1;
      divc    <= 0;
    end else begin
      os_tick <= 1'b0;
      divc    <= divc + 1;
    end
  end

  always @(posedge clk) if (os_tick) tcount <= tcount + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_tick(input int target);
    while (tcount < target) @(negedge clk);
  endtask

  // sends one byte; checks R2, R3, R4, R7; optional mid-frame write and held clear
  task automatic send_frame(input logic [7:0] b, input bit mid_write, input bit hold_clr,
                            input bit b2b, output int ft, output int dt);
    int wt;
    int guard;
    @(negedge clk);
    clr_done = 1'b1;
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0; clr_done = hold_clr;
    wt = tcount;
    chk(busy == 1'b1, "R7 busy after write", busy, 1);
    guard = 0;
    while (txd && guard < 2000) begin @(negedge clk); guard++; end
    ft = tcount;
    chk((ft - wt) >= 1 && (ft - wt) <= 16, "R3 start latency ticks", ft - wt, 16);
    if (b2b)
      chk(ft - last_done_tick == 16, "R9 stop bit ticks before next start", ft - last_done_tick, 16);
    for (int i = 0; i < 9; i++) begin
      logic exp_bit;
      wait_tick(ft + 8 + 16 * i);
      exp_bit = (i == 0) ? 1'b0 : b[i-1];
      chk(txd == exp_bit, $sformatf("R2 frame bit %0d", i), txd, exp_bit);
      if (mid_write && i == 4) begin
        wr_en = 1'b1; wr_data = ~b;
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    wait_tick(ft + 143);
    chk(done == 1'b0 && busy == 1'b1, "R4 not done before 10th wrap", done, 0);
    wait_tick(ft + 144);
    dt = tcount;
    last_done_tick = dt;
    chk(busy == 1'b0, "R4 busy falls at 10th wrap", busy, 0);
    chk(done == !hold_clr, hold_clr ? "R6 clear beats set" : "R4 done at 10th wrap",
        done, !hold_clr);
    if (!b2b) begin
      wait_tick(ft + 152);
      chk(txd == 1'b1, "R2 stop bit", txd, 1);
      chk(busy == 1'b0, "R8 idle after frame", busy, 0);
    end
    clr_done = 1'b0;
  endtask

  task automatic t_reset;
    chk(txd == 1'b1, "R1 txd reset", txd, 1);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
  endtask

  task automatic t_basic;
    int ft, dt;
    tick_div = 1;
    send_frame(8'hA5, 1'b0, 1'b0, 1'b0, ft, dt);
    tick_div = 3;
    send_frame(8'h3C, 1'b0, 1'b0, 1'b0, ft, dt);
    send_frame(8'h81, 1'b0, 1'b0, 1'b0, ft, dt);
  endtask

  task automatic t_sticky;
    int t0;
    t0 = tcount;
    wait_tick(t0 + 50);
    chk(done == 1'b1, "R5 done stays set", done, 1);
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
    chk(done == 1'b0, "R5 done cleared by pulse", done, 0);
  endtask

  task automatic t_idle;
    int t0;
    bit ok;
    t0 = tcount;
    ok = 1'b1;
    while (tcount < t0 + 40) begin
      if (txd !== 1'b1 || busy !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R8 line high while idle", txd, 1);
  endtask

  task automatic t_busy_write;
    int ft, dt;
    tick_div = 2;
    send_frame(8'h5A, 1'b1, 1'b0, 1'b0, ft, dt);
    // the ignored byte must not start a second frame
    t_idle();
  endtask

  task automatic t_clear_priority;
    int ft, dt;
    tick_div = 1;
    send_frame(8'hF0, 1'b0, 1'b1, 1'b0, ft, dt);
  endtask

  task automatic t_back_to_back;
    int ft, dt;
    tick_div = 1;
    send_frame(8'h0F, 1'b0, 1'b0, 1'b1, ft, dt);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1, ft, dt);
    send_frame(8'h96, 1'b0, 1'b0, 1'b0, ft, dt);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_sticky();
    t_busy_write();
    t_clear_priority();
    t_back_to_back();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule